// File: doc/BRIEF.md
# Event Timer Register Front End

This block is the software-facing half of a multi-channel event timer. It decodes single-word reads and writes in a 1 KB window over a simple synchronous request bus. Read data comes back one cycle after the request. The block holds a read-only capability word, a small global configuration, a per-channel interrupt status register and the 64-bit main counter. Accesses that land in the channel area are forwarded to the channel instances, and the block returns their read data.

The main counter advances by one on each `tick` while the global enable is set. It holds its value while the enable is clear. Both halves of the counter can be written at any time. When the enable turns on, the block sends a one-cycle arm strobe to every channel whose comparator is not all ones. When the enable turns off, the block clears all status bits and tells every channel to withdraw its interrupt. The channel comparators and the interrupt routing live outside this block.

Top module: `evt_timer_regs`

## Requirements
- R1: After reset the counter, the configuration and the status all read as zero. `rvalid`, `armPulse`, `irqClear` and the configuration outputs are all low.
- R2: `rvalid` is high in exactly the cycle after a read request and at no other time. Write requests never produce `rvalid`.
- R3: Offset 0x000 reads 0x8086A001 with (implemented channels − 1) placed in bits 12:8. Offset 0x004 reads the tick period in femtoseconds. Writes to either offset are ignored.
- R4: At offset 0x010, only bit 0 (enable) and bit 1 (alternate route) can be written, and all other bits read as zero. Offset 0x014 reads as zero and ignores writes.
- R5: While enabled, the counter adds one for each cycle in which `tick` is high. While disabled, it holds its value. On re-enable, counting resumes from the held value. The counter's low and high words read at 0x0F0 and 0x0F4.
- R6: A write to 0x0F0 or 0x0F4 replaces only the addressed 32-bit half. This works whether or not the block is enabled. In a cycle with such a write, the tick is not counted.
- R7: Status bit n (offset 0x020, bit n) is set by `chIrqSet[n]` while the block is enabled. Writing ones to the status register clears the matching bits that are set, and `irqClear` pulses for one cycle on exactly those bits.
- R8: When a configuration write turns the enable from 0 to 1, `armPulse` pulses for one cycle with the value ~`chCmpAllOnes`. At all other times `armPulse` is zero.
- R9: When a configuration write turns the enable from 1 to 0, the status register is cleared and `irqClear` pulses with every channel's bit set for one cycle.
- R10: An aligned access at 0x100 + 0x20·n + 4·w, with n below the channel count, drives `chSel` one-hot at bit n and `chWord` = w. `chWe` is high for writes. A read returns word n of `chRdataBus` (bits 32n+31:32n).
- R11: An access to a channel number n at or above the implemented count selects no channel and reads as zero.
- R12: An access with a nonzero `addr[1:0]`, or to an unmapped global offset, reads as zero and changes nothing.
- R13: The implemented channel count is the `CHANNELS` parameter clamped to the range 3 to 32. The capability field reflects the clamped value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Bus request |
| we | input | 1 | Request is a write |
| addr | input | 10 | Byte address in the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with `rvalid` |
| rvalid | output | 1 | Read data valid, one cycle after a read request |
| tick | input | 1 | Counter advance qualifier |
| chWe | output | 1 | Forwarded channel write |
| chSel | output | NCH | One-hot channel select |
| chWord | output | 3 | Word index inside the channel slot |
| chWdata | output | 32 | Forwarded write data |
| chRdataBus | input | NCH·32 | Read words from the channels, channel n at bits 32n+31:32n |
| chCmpAllOnes | input | NCH | Channel comparator is all ones |
| chIrqSet | input | NCH | Channel requests its status bit |
| armPulse | output | NCH | One-cycle re-arm strobe per channel |
| irqClear | output | NCH | One-cycle interrupt withdraw per channel |
| cfgEnable | output | 1 | Global enable |
| cfgAltRoute | output | 1 | Alternate routing select |

## Verification
If the enable flag is wrong, it shows up within one cycle as a spurious or missing `armPulse` or `irqClear`, and on the next counter read as a counter that drifted or stalled. A wrong counter or a wrong status bit is not visible on any dedicated pin. It appears in the first read of that register after the error. For this reason the bench reads the counter and the status often and compares every output against a cycle-level model on every clock. Decode faults show up the same cycle on `chSel`/`chWe`, or one cycle later on `rdata`.

// File: rtl/etr_pkg.sv
package etr_pkg;
  localparam int DW = 32;
  localparam int CNT_W = 64;
  localparam int AW = 10;
  localparam int IW = 5;
  localparam int SLOT_LG = 5;
  localparam logic [31:0] CAP_BASE = 32'h8086_A001;
  localparam int CAP_CNT_LSB = 8;
  localparam logic [1:0] CFG_WMASK = 2'b11;

  localparam logic [AW-1:0] OFF_CAPLO = 10'h000;
  localparam logic [AW-1:0] OFF_CAPHI = 10'h004;
  localparam logic [AW-1:0] OFF_CFGLO = 10'h010;
  localparam logic [AW-1:0] OFF_CFGHI = 10'h014;
  localparam logic [AW-1:0] OFF_STAT  = 10'h020;
  localparam logic [AW-1:0] OFF_CNTLO = 10'h0F0;
  localparam logic [AW-1:0] OFF_CNTHI = 10'h0F4;
  localparam logic [AW-1:0] CH_BASE   = 10'h100;

  typedef enum logic [2:0] {
    SRC_ZERO, SRC_CAPLO, SRC_CAPHI, SRC_CFG, SRC_STAT, SRC_CNTLO, SRC_CNTHI, SRC_CHAN
  } rdSrc_e;

  typedef struct packed {
    logic   rdEn;
    rdSrc_e rdSrc;
    logic   wrCfg;
    logic   wrStat;
    logic   wrCntLo;
    logic   wrCntHi;
  } regStb_t;
endpackage

// File: rtl/etr_ctrl.sv
module etr_ctrl
  import etr_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  output regStb_t          stb,
  output logic [NCH-1:0]   chSel,
  output logic [IW-1:0]    chIdx
);
  logic          aligned;
  logic          inChan;
  logic          idxOk;
  logic          chanHit;
  logic [AW-1:0] rel;

  assign aligned = (addr[1:0] == 2'b00);
  assign inChan  = (addr >= CH_BASE);
  assign rel     = addr - CH_BASE;
  assign chIdx   = rel[AW-1:SLOT_LG];
  assign idxOk   = (32'(chIdx) < NCH);
  assign chanHit = req && aligned && inChan && idxOk;

  for (genvar i = 0; i < NCH; i++) begin : g_sel
    assign chSel[i] = chanHit && (chIdx == IW'(i));
  end

  always_comb begin
    stb       = '0;
    stb.rdSrc = SRC_ZERO;
    stb.rdEn  = req && !we;
    if (chanHit) begin
      stb.rdSrc = SRC_CHAN;
    end else if (req && aligned && !inChan) begin
      unique case (addr)
        OFF_CAPLO: stb.rdSrc = SRC_CAPLO;
        OFF_CAPHI: stb.rdSrc = SRC_CAPHI;
        OFF_CFGLO: begin
          stb.rdSrc = SRC_CFG;
          stb.wrCfg = we;
        end
        OFF_STAT: begin
          stb.rdSrc  = SRC_STAT;
          stb.wrStat = we;
        end
        OFF_CNTLO: begin
          stb.rdSrc   = SRC_CNTLO;
          stb.wrCntLo = we;
        end
        OFF_CNTHI: begin
          stb.rdSrc   = SRC_CNTHI;
          stb.wrCntHi = we;
        end
        default: stb.rdSrc = SRC_ZERO;
      endcase
    end
  end

  p_sel_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(chSel));
  p_misaligned_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    (req && addr[1:0] != 2'b00) |-> (chSel == '0 && !stb.wrCfg && !stb.wrStat
                                     && !stb.wrCntLo && !stb.wrCntHi));
endmodule

// File: rtl/etr_dpath.sv
module etr_dpath
  import etr_pkg::*;
#(
  parameter int          NCH       = 3,
  parameter logic [31:0] PERIOD_FS = 32'd10_000_000
) (
  input  logic               clk,
  input  logic               rst,
  input  regStb_t            stb,
  input  logic [IW-1:0]      chIdx,
  input  logic [DW-1:0]      wdata,
  input  logic               tick,
  input  logic [NCH-1:0]     chIrqSet,
  input  logic [NCH-1:0]     chCmpAllOnes,
  input  logic [NCH*DW-1:0]  chRdataBus,
  output logic [DW-1:0]      rdata,
  output logic               rvalid,
  output logic               cfgEnable,
  output logic               cfgAltRoute,
  output logic [NCH-1:0]     armPulse,
  output logic [NCH-1:0]     irqClear
);
  localparam logic [31:0] CAP_LO = CAP_BASE | (32'(NCH - 1) << CAP_CNT_LSB);

  logic [CNT_W-1:0] cnt;
  logic [1:0]       cfgQ;
  logic [NCH-1:0]   isr;
  logic [1:0]       cfgNew;
  logic             enRise;
  logic             enFall;
  logic [NCH-1:0]   w1c;
  logic [DW-1:0]    chanWord;
  logic [DW-1:0]    rdMux;

  assign cfgEnable   = cfgQ[0];
  assign cfgAltRoute = cfgQ[1];
  assign cfgNew      = wdata[1:0] & CFG_WMASK;
  assign enRise      = stb.wrCfg && cfgNew[0] && !cfgQ[0];
  assign enFall      = stb.wrCfg && !cfgNew[0] && cfgQ[0];
  assign w1c         = stb.wrStat ? wdata[NCH-1:0] : '0;

  always_comb begin
    chanWord = '0;
    for (int i = 0; i < NCH; i++) begin
      if (chIdx == IW'(i)) chanWord = chRdataBus[i*DW +: DW];
    end
  end

  always_comb begin
    unique case (stb.rdSrc)
      SRC_CAPLO: rdMux = CAP_LO;
      SRC_CAPHI: rdMux = PERIOD_FS;
      SRC_CFG:   rdMux = {30'b0, cfgQ};
      SRC_STAT:  rdMux = DW'(isr);
      SRC_CNTLO: rdMux = cnt[31:0];
      SRC_CNTHI: rdMux = cnt[CNT_W-1:32];
      SRC_CHAN:  rdMux = chanWord;
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      cfgQ     <= '0;
      isr      <= '0;
      armPulse <= '0;
      irqClear <= '0;
      rdata    <= '0;
      rvalid   <= 1'b0;
    end else begin
      rvalid <= stb.rdEn;
      if (stb.rdEn) rdata <= rdMux;
      if (stb.wrCfg) cfgQ <= cfgNew;

      if (stb.wrCntLo)      cnt[31:0]       <= wdata;
      else if (stb.wrCntHi) cnt[CNT_W-1:32] <= wdata;
      else if (cfgQ[0] && tick) cnt <= cnt + 1'b1;

      if (enFall) isr <= '0;
      else        isr <= (isr & ~w1c) | (cfgQ[0] ? chIrqSet : '0);

      irqClear <= enFall ? '1 : (w1c & isr);
      armPulse <= enRise ? ~chCmpAllOnes : '0;
    end
  end

  p_count_step_r5: assert property (@(posedge clk) disable iff (rst)
    (cfgQ[0] && tick && !stb.wrCntLo && !stb.wrCntHi) |=> (cnt == $past(cnt) + 1'b1));
  p_count_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!cfgQ[0] && !stb.wrCntLo && !stb.wrCntHi) |=> $stable(cnt));
  p_arm_on_rise_r8: assert property (@(posedge clk) disable iff (rst)
    (armPulse != '0) |-> (cfgQ[0] && !$past(cfgQ[0])));
  p_withdraw_on_fall_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(cfgQ[0]) |-> (isr == '0 && irqClear == '1));
  p_clear_only_set_r7: assert property (@(posedge clk) disable iff (rst)
    (cfgQ[0] && irqClear != '0) |-> ((irqClear & ~$past(isr)) == '0));
endmodule

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
  import etr_pkg::*;
#(
  parameter int          CHANNELS  = 3,
  parameter logic [31:0] PERIOD_FS = 32'd10_000_000,
  localparam int         NCH = (CHANNELS < 3) ? 3 : ((CHANNELS > 32) ? 32 : CHANNELS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              we,
  input  logic [9:0]        addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              rvalid,
  input  logic              tick,
  output logic              chWe,
  output logic [NCH-1:0]    chSel,
  output logic [2:0]        chWord,
  output logic [31:0]       chWdata,
  input  logic [NCH*32-1:0] chRdataBus,
  input  logic [NCH-1:0]    chCmpAllOnes,
  input  logic [NCH-1:0]    chIrqSet,
  output logic [NCH-1:0]    armPulse,
  output logic [NCH-1:0]    irqClear,
  output logic              cfgEnable,
  output logic              cfgAltRoute
);
  regStb_t       stb;
  logic [IW-1:0] chIdx;

  etr_ctrl #(.NCH(NCH)) u_ctrl (
    .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr),
    .stb(stb), .chSel(chSel), .chIdx(chIdx)
  );

  etr_dpath #(.NCH(NCH), .PERIOD_FS(PERIOD_FS)) u_dpath (
    .clk(clk), .rst(rst), .stb(stb), .chIdx(chIdx), .wdata(wdata), .tick(tick),
    .chIrqSet(chIrqSet), .chCmpAllOnes(chCmpAllOnes), .chRdataBus(chRdataBus),
    .rdata(rdata), .rvalid(rvalid), .cfgEnable(cfgEnable), .cfgAltRoute(cfgAltRoute),
    .armPulse(armPulse), .irqClear(irqClear)
  );

  assign chWe    = req && we && (chSel != '0);
  assign chWord  = addr[4:2];
  assign chWdata = wdata;

  p_read_latency_r2: assert property (@(posedge clk) disable iff (rst)
    (req && !we) |=> rvalid);
  p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (rst)
    !(req && !we) |=> !rvalid);
endmodule

// File: tb/evt_timer_regs_bench.sv
module evt_timer_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0, we = 1'b0, tick = 1'b0;
  logic [9:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [N-1:0] cmpOnes = '0, irqSet = '0;
  logic [N*32-1:0] chRd;
  logic [31:0] rdata, chWdata;
  logic rvalid, chWe, cfgEnable, cfgAltRoute;
  logic [N-1:0] chSel, armPulse, irqClear;
  logic [2:0] chWord;

  logic [31:0] cRd, wRd;
  logic cRv, wRv, cWe, wWe, cEn, wEn, cAlt, wAlt;
  logic [2:0] cSel, cArm, cClr, cWord, wWord;
  logic [31:0] cWd, wWd;
  logic [31:0] wSel, wArm, wClr;

  int nChecks = 0, nErr = 0;
  bit started = 0, done = 0;

  for (genvar i = 0; i < N; i++) begin : g_rd
    assign chRd[i*32 +: 32] = {16'hC0DE, 8'(i), 8'h5A};
  end

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_timer_regs #(.CHANNELS(N)) u_evt_timer_regs (
    .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rvalid(rvalid), .tick(tick), .chWe(chWe), .chSel(chSel),
    .chWord(chWord), .chWdata(chWdata), .chRdataBus(chRd), .chCmpAllOnes(cmpOnes),
    .chIrqSet(irqSet), .armPulse(armPulse), .irqClear(irqClear),
    .cfgEnable(cfgEnable), .cfgAltRoute(cfgAltRoute));

  evt_timer_regs #(.CHANNELS(1)) u_clamp (
    .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rdata(cRd), .rvalid(cRv), .tick(tick), .chWe(cWe), .chSel(cSel),
    .chWord(cWord), .chWdata(cWd), .chRdataBus('0), .chCmpAllOnes('0),
    .chIrqSet('0), .armPulse(cArm), .irqClear(cClr),
    .cfgEnable(cEn), .cfgAltRoute(cAlt));

  evt_timer_regs #(.CHANNELS(40)) u_wide (
    .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rdata(wRd), .rvalid(wRv), .tick(tick), .chWe(wWe), .chSel(wSel),
    .chWord(wWord), .chWdata(wWd), .chRdataBus('0), .chCmpAllOnes('0),
    .chIrqSet('0), .armPulse(wArm), .irqClear(wClr),
    .cfgEnable(wEn), .cfgAltRoute(wAlt));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference state
  longint unsigned mCnt;
  bit [1:0] mCfg;
  bit [N-1:0] mIsr, mArm, mClr;
  bit mRv;
  bit [31:0] mRd;
  string mTag, mClrTag;

  always @(posedge clk) begin
    if (rst) begin
      mCnt = 0; mCfg = 0; mIsr = 0; mArm = 0; mClr = 0; mRv = 0; mRd = 0;
      mTag = "R1"; mClrTag = "R1";
    end else begin
      bit al, ch, ok, wrote, rise, fall;
      int unsigned idx;
      bit [N-1:0] selExp, wst;
      bit [31:0] val;
      string tg;
      al = (addr[1:0] == 0);
      ch = (addr >= 10'h100);
      idx = (int'(addr) - 256) >>> 5;
      ok = ch && idx < N;
      selExp = (req && al && ok) ? N'(1 << idx) : '0;
      chk(ok ? "R10 chSel" : "R11 chSel", chSel, selExp);
      chk("R10 chWe", chWe, req && we && selExp != 0);
      if (selExp != 0) chk("R10 chWord", chWord, addr[4:2]);
      val = 0; tg = "R12";
      if (!al) begin val = 0; tg = "R12"; end
      else if (ch) begin
        val = ok ? {16'hC0DE, 8'(idx), 8'h5A} : 32'h0;
        tg = ok ? "R10" : "R11";
      end else case (addr)
        10'h000: begin val = 32'h8086A201; tg = "R3"; end
        10'h004: begin val = 32'd10000000; tg = "R3"; end
        10'h010: begin val = {30'b0, mCfg}; tg = "R4"; end
        10'h014: begin val = 0; tg = "R4"; end
        10'h020: begin val = 32'(mIsr); tg = "R7"; end
        10'h0F0: begin val = mCnt[31:0]; tg = "R5"; end
        10'h0F4: begin val = mCnt[63:32]; tg = "R6"; end
        default: begin val = 0; tg = "R12"; end
      endcase
      wrote = 0; rise = 0; fall = 0; wst = 0;
      if (req && we && al && !ch) begin
        case (addr)
          10'h010: begin
            rise = wdata[0] && !mCfg[0];
            fall = !wdata[0] && mCfg[0];
          end
          10'h020: wst = wdata[N-1:0];
          10'h0F0: wrote = 1;
          10'h0F4: wrote = 1;
          default: ;
        endcase
      end
      mRv = req && !we;
      if (mRv) begin mRd = val; mTag = tg; end
      mArm = rise ? ~cmpOnes : '0;
      mClr = fall ? '1 : (wst & mIsr);
      mClrTag = fall ? "R9" : "R7";
      if (fall) mIsr = 0;
      else mIsr = (mIsr & ~wst) | (mCfg[0] ? irqSet : '0);
      if (wrote && addr == 10'h0F0) mCnt = {mCnt[63:32], wdata};
      else if (wrote) mCnt = {wdata, mCnt[31:0]};
      else if (mCfg[0] && tick) mCnt = mCnt + 1;
      if (req && we && al && addr == 10'h010) mCfg = wdata[1:0];
    end
  end

  always @(negedge clk) begin
    if (!rst && started && !done) begin
      chk("R2 rvalid", rvalid, mRv);
      if (mRv) chk({mTag, " rdata"}, rdata, mRd);
      chk("R8 armPulse", armPulse, mArm);
      chk({mClrTag, " irqClear"}, irqClear, mClr);
      chk("R4 cfg", {cfgAltRoute, cfgEnable}, mCfg);
    end
  end

  task automatic op(input bit w, input bit [9:0] a, input bit [31:0] d);
    @(negedge clk); req = 1; we = w; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rdChk(input string tag, input bit [9:0] a, input bit [31:0] exp);
    op(0, a, 0);
    chk(tag, rdata, exp);
  endtask

  task automatic finishRun;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nErr++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    started = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rvalid", rvalid, 0);
    chk("R1 pulses", {armPulse, irqClear, cfgEnable, cfgAltRoute}, 0);
    rdChk("R1 counter low", 10'h0F0, 0);
    rdChk("R1 counter high", 10'h0F4, 0);
    rdChk("R1 status", 10'h020, 0);
    rdChk("R1 cfg", 10'h010, 0);
    // R3 capability, R13 clamp
    rdChk("R3 cap low", 10'h000, 32'h8086A201);
    chk("R13 clamp low", cRd, 32'h8086A201);
    chk("R13 clamp high", wRd, 32'h8086BF01);
    rdChk("R3 period", 10'h004, 32'd10000000);
    op(1, 10'h000, 32'h0);
    op(1, 10'h004, 32'h1);
    rdChk("R3 cap after write", 10'h000, 32'h8086A201);
    // R4 masks
    op(1, 10'h014, 32'hFFFFFFFF);
    rdChk("R4 cfg high", 10'h014, 0);
    op(1, 10'h010, 32'hFFFFFFFE);
    rdChk("R4 cfg masked", 10'h010, 32'h2);
    // R8 enable with one channel comparator all ones
    cmpOnes = 3'b010;
    op(1, 10'h010, 32'h3);
    tick = 1;
    repeat (5) @(negedge clk);
    tick = 0;
    repeat (2) @(negedge clk);
    tick = 1;
    rdChk("R5 counter runs", 10'h0F0, 32'd6);
    // R7 status set and clear
    irqSet = 3'b101;
    @(negedge clk);
    irqSet = 0;
    rdChk("R7 status set", 10'h020, 32'h5);
    op(1, 10'h020, 32'h1);
    rdChk("R7 status cleared", 10'h020, 32'h4);
    op(1, 10'h020, 32'h2);
    rdChk("R7 clear unset bit", 10'h020, 32'h4);
    // R6 counter writes while running
    op(1, 10'h0F0, 32'hFFFFFFF0);
    op(1, 10'h0F4, 32'h1);
    op(0, 10'h0F0, 0);
    op(0, 10'h0F4, 0);
    // R9 disable
    op(1, 10'h010, 32'h0);
    rdChk("R9 status cleared", 10'h020, 0);
    op(0, 10'h0F0, 0);
    begin
      logic [31:0] held;
      held = rdata;
      repeat (3) @(negedge clk);
      rdChk("R5 frozen", 10'h0F0, held);
    end
    op(1, 10'h0F0, 32'h12345678);
    op(1, 10'h0F4, 32'h9ABCDEF0);
    rdChk("R6 low half kept", 10'h0F0, 32'h12345678);
    rdChk("R6 high half", 10'h0F4, 32'h9ABCDEF0);
    // R8 re-enable cases
    cmpOnes = 3'b111;
    op(1, 10'h001, 32'h1);
    rdChk("R12 misaligned cfg write", 10'h010, 0);
    op(1, 10'h010, 32'h1);
    op(1, 10'h010, 32'h0);
    cmpOnes = 3'b000;
    op(1, 10'h010, 32'h1);
    rdChk("R5 resumes", 10'h0F4, 32'h9ABCDEF0);
    // R10/R11 channel forwarding
    rdChk("R10 ch0 word0", 10'h100, 32'hC0DE005A);
    rdChk("R10 ch1 word2", 10'h128, 32'hC0DE015A);
    rdChk("R10 ch2 word1", 10'h144, 32'hC0DE025A);
    op(1, 10'h10C, 32'hAAAA5555);
    rdChk("R11 ch3", 10'h160, 0);
    rdChk("R11 ch23", 10'h3FC, 0);
    op(1, 10'h3E0, 32'h1);
    // R12 misaligned and unmapped
    rdChk("R12 misaligned", 10'h0F2, 0);
    rdChk("R12 unmapped", 10'h030, 0);
    rdChk("R12 misaligned chan", 10'h101, 0);
    tick = 0;
    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule